// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block keeps the address of the instruction being executed and works out the following one on each clock edge where it is enabled. Three kinds of update are supported. A sequential step moves forward by the instruction size. An absolute jump loads a full target address. A relative branch adds a signed displacement to the current address.

The instruction size depends on a parameter. It can be a constant 4 for byte-addressed 32-bit instructions, a constant 1 for word-addressed instruction memory, or a per-cycle length in bytes that the decoder supplies. A single adder is shared between stepping and relative branching. The adder's second operand is either the step size or the sign-extended displacement. A final selector picks either the adder output or the absolute target.

Top module: `pc_next_unit`

## Requirements
- R1: When `en` is low and `rst` is low, `pc` keeps its value at the next clock edge, whatever the other inputs are.
- R2: With `STEP_MODE`=0 (byte fixed), an enabled cycle with `jump_sel`=0 and `branch_sel`=0 adds 4 to `pc`.
- R3: With `STEP_MODE`=1 (word fixed), an enabled sequential cycle adds 1 to `pc`.
- R4: With `STEP_MODE`=2 (variable), an enabled sequential cycle adds the unsigned 4-bit `step_len` to `pc`.
- R5: With `STEP_MODE`=2, a sequential cycle with `step_len`=0 leaves `pc` unchanged.
- R6: An enabled cycle with `jump_sel`=1 loads `jump_target` into `pc`.
- R7: An enabled cycle with `jump_sel`=0 and `branch_sel`=1 loads `pc` plus `br_offset`, where `br_offset` is read as two's complement. A negative offset moves `pc` backwards.
- R8: When `jump_sel` and `branch_sel` are both 1 in an enabled cycle, the jump wins and `pc` becomes `jump_target`.
- R9: A synchronous `rst` loads `RESET_VEC` (default 0) into `pc` even while `en` is high.
- R10: Every addition wraps modulo 2^`PC_W`.
- R11: In the fixed modes (`STEP_MODE` 0 or 1), `step_len` has no effect on `pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Update enable |
| step_len | input | 4 | Instruction length in bytes (used in variable mode only) |
| jump_sel | input | 1 | Select the absolute jump |
| branch_sel | input | 1 | Select the relative branch |
| jump_target | input | PC_W | Absolute target address |
| br_offset | input | OFS_W | Signed branch displacement |
| pc | output | PC_W | Registered program counter |

## Verification
There are two cases where requests can arrive in the same cycle. The first is a jump and a relative branch requested together. The bench raises `jump_sel` and `branch_sel` together, with an offset chosen so that the branch result and the jump target differ. It passes only if the jump target appears. The second is reset applied while enable and a jump are active. That case passes only if `pc` shows the reset vector rather than the target.

// File: rtl/pc_next_unit.sv
module pc_next_unit #(
  parameter int PC_W = 32,
  parameter int OFS_W = 16,
  parameter int STEP_MODE = 0,
  parameter logic [PC_W-1:0] RESET_VEC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [3:0]       step_len,
  input  logic             jump_sel,
  input  logic             branch_sel,
  input  logic [PC_W-1:0]  jump_target,
  input  logic [OFS_W-1:0] br_offset,
  output logic [PC_W-1:0]  pc
);
  localparam logic [PC_W-1:0] FIXED_STEP = (STEP_MODE == 1) ? PC_W'(1) : PC_W'(4);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] step_amt;
  logic [PC_W-1:0] ofs_ext;
  logic [PC_W-1:0] addend;
  logic [PC_W-1:0] sum;
  logic [PC_W-1:0] pc_nxt;

  generate
    if (STEP_MODE == 2) begin : g_var_step
      assign step_amt = {{(PC_W-4){1'b0}}, step_len};
    end else begin : g_fixed_step
      logic unused_len;
      assign unused_len = ^step_len;
      assign step_amt = FIXED_STEP;
    end
  endgenerate

  assign ofs_ext = {{(PC_W-OFS_W){br_offset[OFS_W-1]}}, br_offset};
  assign addend  = branch_sel ? ofs_ext : step_amt;
  assign sum     = pc_q + addend;
  assign pc_nxt  = jump_sel ? jump_target : sum;

  always_ff @(posedge clk) begin
    if (rst)     pc_q <= RESET_VEC;
    else if (en) pc_q <= pc_nxt;
  end

  assign pc = pc_q;
endmodule

module pc_next_unit_chk #(
  parameter int PC_W = 32,
  parameter int OFS_W = 16,
  parameter int STEP_MODE = 0,
  parameter logic [PC_W-1:0] RESET_VEC = '0
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [3:0]       step_len,
  input logic             jump_sel,
  input logic             branch_sel,
  input logic [PC_W-1:0]  jump_target,
  input logic [OFS_W-1:0] br_offset,
  input logic [PC_W-1:0]  pc
);
  logic [PC_W-1:0] exp_step;
  assign exp_step = (STEP_MODE == 2) ? PC_W'(step_len) : (STEP_MODE == 1 ? PC_W'(1) : PC_W'(4));

  p_reset_vec_r9: assert property (@(posedge clk) rst |=> pc == RESET_VEC);

  p_hold_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !en |=> pc == $past(pc));

  p_jump_load_r6_r8: assert property (@(posedge clk) disable iff (rst)
    (en && jump_sel) |=> pc == $past(jump_target));

  p_rel_branch_r7_r10: assert property (@(posedge clk) disable iff (rst)
    (en && !jump_sel && branch_sel) |=>
      pc == $past(pc) + PC_W'($signed($past(br_offset))));

  p_seq_step_r2_r3_r4_r5: assert property (@(posedge clk) disable iff (rst)
    (en && !jump_sel && !branch_sel) |=> pc == $past(pc) + $past(exp_step));
endmodule

bind pc_next_unit pc_next_unit_chk #(
  .PC_W(PC_W), .OFS_W(OFS_W), .STEP_MODE(STEP_MODE), .RESET_VEC(RESET_VEC)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .step_len(step_len), .jump_sel(jump_sel),
  .branch_sel(branch_sel), .jump_target(jump_target), .br_offset(br_offset), .pc(pc)
);

// File: tb/pc_next_unit_tb.sv
`timescale 1ns/1ps
module pc_next_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [3:0]  step_len = '0;
  logic        jump_sel = 1'b0;
  logic        branch_sel = 1'b0;
  logic [31:0] jump_target = '0;
  logic [15:0] br_offset = '0;
  logic [31:0] pc_b, pc_w, pc_v;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pc_next_unit #(.STEP_MODE(0)) u_dut (
    .clk(clk), .rst(rst), .en(en), .step_len(step_len), .jump_sel(jump_sel),
    .branch_sel(branch_sel), .jump_target(jump_target), .br_offset(br_offset), .pc(pc_b));
  pc_next_unit #(.STEP_MODE(1)) u_dut_word (
    .clk(clk), .rst(rst), .en(en), .step_len(step_len), .jump_sel(jump_sel),
    .branch_sel(branch_sel), .jump_target(jump_target), .br_offset(br_offset), .pc(pc_w));
  pc_next_unit #(.STEP_MODE(2)) u_dut_var (
    .clk(clk), .rst(rst), .en(en), .step_len(step_len), .jump_sel(jump_sel),
    .branch_sel(branch_sel), .jump_target(jump_target), .br_offset(br_offset), .pc(pc_v));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cycle(logic e, logic j, logic b, logic [3:0] sl, logic [31:0] tgt, logic [15:0] ofs);
    @(negedge clk);
    en = e; jump_sel = j; branch_sel = b; step_len = sl; jump_target = tgt; br_offset = ofs;
    @(posedge clk);
    #1;
  endtask

  task automatic load_all(logic [31:0] a);
    cycle(1, 1, 0, 0, a, 0);
  endtask

  task automatic t_reset();
    check("R9 reset byte", pc_b, 32'h0);
    check("R9 reset word", pc_w, 32'h0);
    check("R9 reset var", pc_v, 32'h0);
  endtask

  task automatic t_sequential();
    load_all(32'h100);
    check("R6 jump load", pc_b, 32'h100);
    cycle(1, 0, 0, 4'd7, 0, 0);
    check("R2 byte +4 (R11 len ignored)", pc_b, 32'h104);
    check("R3 word +1 (R11 len ignored)", pc_w, 32'h101);
    check("R4 var +7", pc_v, 32'h107);
    cycle(1, 0, 0, 4'd15, 0, 0);
    check("R4 var +15", pc_v, 32'h116);
    check("R2 byte +4 again", pc_b, 32'h108);
    cycle(1, 0, 0, 4'd0, 0, 0);
    check("R5 var len 0 holds", pc_v, 32'h116);
    check("R11 byte len 0 ignored", pc_b, 32'h10C);
    check("R11 word len 0 ignored", pc_w, 32'h103);
  endtask

  task automatic t_hold();
    load_all(32'h200);
    cycle(0, 1, 1, 4'd3, 32'hDEAD_BEEF, 16'h0010);
    check("R1 hold byte", pc_b, 32'h200);
    check("R1 hold var", pc_v, 32'h200);
  endtask

  task automatic t_branch();
    load_all(32'h1000);
    cycle(1, 0, 1, 4'd3, 0, 16'h0040);
    check("R7 positive offset", pc_b, 32'h1040);
    cycle(1, 0, 1, 4'd3, 0, 16'hFFF8);
    check("R7 negative offset", pc_v, 32'h1038);
    cycle(1, 0, 1, 4'd3, 0, 16'h8000);
    check("R7 most negative offset", pc_w, 32'h1038 - 32'h8000);
  endtask

  task automatic t_priority();
    load_all(32'h400);
    cycle(1, 1, 1, 4'd2, 32'h0ABC_0000, 16'h0010);
    check("R8 jump beats branch byte", pc_b, 32'h0ABC_0000);
    check("R8 jump beats branch var", pc_v, 32'h0ABC_0000);
  endtask

  task automatic t_wrap();
    load_all(32'hFFFF_FFFE);
    cycle(1, 0, 0, 4'd5, 0, 0);
    check("R10 byte wrap", pc_b, 32'h0000_0002);
    check("R10 word no wrap yet", pc_w, 32'hFFFF_FFFF);
    check("R10 var wrap", pc_v, 32'h0000_0003);
    load_all(32'h0000_0004);
    cycle(1, 0, 1, 0, 0, 16'hFFF0);
    check("R10 branch wraps below zero", pc_b, 32'hFFFF_FFF4);
  endtask

  task automatic t_reset_override();
    load_all(32'h5555_0000);
    @(negedge clk);
    rst = 1; en = 1; jump_sel = 1; jump_target = 32'h1234_5678;
    @(posedge clk);
    #1;
    check("R9 reset beats enable byte", pc_b, 32'h0);
    check("R9 reset beats enable var", pc_v, 32'h0);
    @(negedge clk);
    rst = 0; en = 0; jump_sel = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst = 0;
    t_sequential();
    t_hold();
    t_branch();
    t_priority();
    t_wrap();
    t_reset_override();
    finish_run();
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule